// File: doc/BRIEF.md
# Indexed Register Bank-Switch Controller

This block sits on an 8-bit CPU bus inside a cartridge and selects which program-memory and character-memory banks are visible. It also sets how the four nametable quadrants map onto two physical nametable pages. Eight internal 3-bit registers hold its state. Software never addresses them directly. It first writes a register number to an index port. It then writes or reads that register through a data port.

The program bank, the character bank and the mirroring code are each built from bits spread across several registers. A strap input models a board wiring option. With the strap set, data bit 2 is forced high on every write, and on reads of the data port bit 2 is not driven, so it comes from open bus. An open-bus input carries the last value seen on the data bus. Any read that the block does not claim returns that value.

Top module: `idx_bank_ctrl`

## Requirements
- R1: A bus cycle is claimed only when the address lies in 0x4100..0x7FFF. Under mask 0xC101 it must then equal 0x4100 (index port) or 0x4101 (data port). Writes to any other address change no register and no output.
- R2: A write to the index port stores data bits [2:0] as the current register index.
- R3: A write to the data port stores data bits [2:0] into the register chosen by the index. The outputs show the new value from the next clock cycle.
- R4: When `strap` is 1, data bit 2 is forced to 1 before any write is stored. This applies to index writes and to data writes.
- R5: `prg_bank` equals bits [1:0] of register 5 and selects a 32 KiB window.
- R6: With ALT_CHR = 0, `chr_bank` (8 KiB units) is {reg6[1:0], reg4[0], reg2[0]}.
- R7: With ALT_CHR = 1, `chr_bank` is {1'b0, reg4[0], reg6[1:0]}.
- R8: The mirroring code is reg7[2:1]. `nt_sel[i]` gives the page (0 = A, 1 = B) for quadrant i. Code 0 gives 4'b1000 (A,A,A,B). Code 1 gives 4'b1100 (horizontal). Code 2 gives 4'b1010 (vertical). Code 3 gives 4'b0000 (single screen A).
- R9: A read of the data port with `strap` = 0 returns {open_bus[7:3], reg[2:0]}. With `strap` = 1 it returns {open_bus[7:2], reg[1:0]}, where reg is the register selected by the index.
- R10: Any other read, including a read of the index port, returns `open_bus` unchanged.
- R11: Reset clears the index and all eight registers. The outputs then read prg_bank = 0, chr_bank = 0 and nt_sel = 4'b1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 1 | Board option: force data bit 2 on writes, leave it undriven on reads |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_re | input | 1 | Read strobe |
| open_bus | input | 8 | Last value seen on the data bus |
| rd_data | output | 8 | Read data, combinational |
| prg_bank | output | 2 | 32 KiB program bank number |
| chr_bank | output | 4 | 8 KiB character bank number |
| nt_sel | output | 4 | Page select for each nametable quadrant |

## Verification
The bench builds two copies of the block side by side on the same bus, one with ALT_CHR = 0 and one with ALT_CHR = 1. This puts both character-bank layouts under the same stimulus. Every register index is swept against every 3-bit value with the strap off, and then again with the strap on. This covers all mirroring codes, all program banks and every bit that feeds each character-bank layout. Each write is followed by a read-back through the data port. Writes and reads to addresses that miss the decode are checked to leave the outputs, and the read-back of the selected register, unchanged.

// File: rtl/idx_bank_ctrl.sv
module idx_bank_ctrl #(
  parameter bit          ALT_CHR  = 1'b0,
  parameter logic [15:0] DEC_MASK = 16'hC101,
  parameter logic [15:0] IDX_PORT = 16'h4100,
  parameter logic [15:0] DAT_PORT = 16'h4101,
  parameter logic [15:0] WIN_LO   = 16'h4100,
  parameter logic [15:0] WIN_HI   = 16'h7FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [7:0]  open_bus,
  output logic [7:0]  rd_data,
  output logic [1:0]  prg_bank,
  output logic [3:0]  chr_bank,
  output logic [3:0]  nt_sel
);
  logic [7:0][2:0] regs;
  logic [2:0]      idx;
  logic [2:0]      wv;
  logic            in_win, hit_idx, hit_dat;
  logic [2:0]      cur;

  assign wv      = bus_wdata[2:0] | {strap, 2'b00};
  assign in_win  = (bus_addr >= WIN_LO) && (bus_addr <= WIN_HI);
  assign hit_idx = in_win && ((bus_addr & DEC_MASK) == IDX_PORT);
  assign hit_dat = in_win && ((bus_addr & DEC_MASK) == DAT_PORT);
  assign cur     = regs[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      regs <= '0;
    end else if (bus_we) begin
      if (hit_idx) idx <= wv;
      if (hit_dat) regs[idx] <= wv;
    end
  end

  assign prg_bank = regs[5][1:0];

  generate
    if (ALT_CHR) begin : g_chr_alt
      assign chr_bank = {1'b0, regs[4][0], regs[6][1:0]};
    end else begin : g_chr_std
      assign chr_bank = {regs[6][1:0], regs[4][0], regs[2][0]};
    end
  endgenerate

  always_comb begin
    case (regs[7][2:1])
      2'd0:    nt_sel = 4'b1000;
      2'd1:    nt_sel = 4'b1100;
      2'd2:    nt_sel = 4'b1010;
      default: nt_sel = 4'b0000;
    endcase
  end

  always_comb begin
    rd_data = open_bus;
    if (bus_re && hit_dat) begin
      if (strap) rd_data = {open_bus[7:2], cur[1:0]};
      else       rd_data = {open_bus[7:3], cur};
    end
  end
endmodule

module idx_bank_ctrl_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            strap,
  input logic [15:0]     bus_addr,
  input logic [7:0]      bus_wdata,
  input logic            bus_we,
  input logic            bus_re,
  input logic [7:0]      open_bus,
  input logic [7:0]      rd_data,
  input logic [1:0]      prg_bank,
  input logic [3:0]      chr_bank,
  input logic [3:0]      nt_sel,
  input logic [7:0][2:0] regs,
  input logic [2:0]      idx
);
  logic a_idx, a_dat;
  assign a_idx = (bus_addr >= 16'h4100) && (bus_addr <= 16'h7FFF) && ((bus_addr & 16'hC101) == 16'h4100);
  assign a_dat = (bus_addr >= 16'h4100) && (bus_addr <= 16'h7FFF) && ((bus_addr & 16'hC101) == 16'h4101);

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && a_idx |=> idx == $past(bus_wdata[2:0] | {strap, 2'b00})); // R2
  AST_DATA_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && a_dat |=> regs[$past(idx)] == $past(bus_wdata[2:0] | {strap, 2'b00})); // R3
  AST_STRAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && a_dat && strap |=> regs[$past(idx)][2]); // R4
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (a_idx || a_dat)) |=> $stable(regs) && $stable(idx)); // R1
  AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(prg_bank) && $stable(chr_bank) && $stable(nt_sel)); // R5
  AST_QUAD0_A: assert property (@(posedge clk) disable iff (!rst_n)
    nt_sel[0] == 1'b0); // R8
  AST_STRAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && a_dat && strap |-> rd_data[7:2] == open_bus[7:2]); // R9
  AST_OPEN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_re && a_dat) |-> rd_data == open_bus); // R10
endmodule

bind idx_bank_ctrl idx_bank_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strap(strap), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .open_bus(open_bus),
  .rd_data(rd_data), .prg_bank(prg_bank), .chr_bank(chr_bank), .nt_sel(nt_sel),
  .regs(regs), .idx(idx)
);

// File: tb/idx_bank_ctrl_bench.sv
module idx_bank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  open_bus = 8'hA5;
  logic [7:0]  rd_data, rd_alt;
  logic [1:0]  prg_bank, prg_alt;
  logic [3:0]  chr_bank, chr_alt;
  logic [3:0]  nt_sel, nt_alt;

  int tests = 0;
  int fails = 0;
  logic [2:0] mregs [8];
  logic [2:0] midx;

  always #10 clk = ~clk;

  idx_bank_ctrl #(.ALT_CHR(1'b0)) u_idx_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .strap(strap), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .open_bus(open_bus), .rd_data(rd_data),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .nt_sel(nt_sel));

  idx_bank_ctrl #(.ALT_CHR(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .strap(strap), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .open_bus(open_bus), .rd_data(rd_alt),
    .prg_bank(prg_alt), .chr_bank(chr_alt), .nt_sel(nt_alt));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_nt(input logic [1:0] code);
    case (code)
      2'd0: return 4'b1000;
      2'd1: return 4'b1100;
      2'd2: return 4'b1010;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check_outs();
    chk("R5 prg_bank", {6'b0, prg_bank}, {6'b0, mregs[5][1:0]});
    chk("R6 chr_bank", {4'b0, chr_bank}, {4'b0, mregs[6][1:0], mregs[4][0], mregs[2][0]});
    chk("R7 chr_bank alt", {4'b0, chr_alt}, {5'b0, mregs[4][0], mregs[6][1:0]});
    chk("R8 nt_sel", {4'b0, nt_sel}, {4'b0, exp_nt(mregs[7][2:1])});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [15:0] a, input logic [7:0] ob, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; open_bus = ob; bus_re = 1'b1;
    #2;
    chk(req, rd_data, exp);
    bus_re = 1'b0;
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] ob);
    logic [2:0] r = mregs[midx];
    return strap ? {ob[7:2], r[1:0]} : {ob[7:3], r};
  endfunction

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mregs[i] = 3'd0;
    midx = 3'd0;
    repeat (3) @(negedge clk);
    chk("R11 reset prg", {6'b0, prg_bank}, 8'h00);
    chk("R11 reset chr", {4'b0, chr_bank}, 8'h00);
    chk("R11 reset nt_sel", {4'b0, nt_sel}, 8'h08);
    rst_n = 1'b1;
    rd_check("R11 reset readback", 16'h4101, 8'hFF, 8'hF8);

    for (int s = 0; s < 2; s++) begin
      strap = s[0];
      for (int r = 0; r < 8; r++) begin
        for (int v = 0; v < 8; v++) begin
          logic [2:0] eff;
          eff = v[2:0] | {strap, 2'b00};
          wr(16'h4100 | 16'(r << 9), {5'b10101, r[2:0]});
          midx = r[2:0] | {strap, 2'b00};
          wr(16'h4101 | 16'(v << 10), {5'b01010, v[2:0]});
          mregs[midx] = eff;
          check_outs();
          rd_check("R9 readback", 16'h4101, 8'h5A ^ 8'(v << 3), exp_rd(8'h5A ^ 8'(v << 3)));
        end
      end
    end

    strap = 1'b0;
    wr(16'h4100, 8'h05); midx = 3'd5;
    wr(16'h4101, 8'h02); mregs[5] = 3'd2;
    wr(16'h4101, 8'hF9); mregs[5] = 3'd1;
    chk("R3 upper bits dropped", {6'b0, prg_bank}, 8'h01);
    rd_check("R3 readback", 16'h4101, 8'h00, 8'h01);

    wr(16'hC101, 8'h07);
    wr(16'h8101, 8'h07);
    wr(16'h4001, 8'h07);
    wr(16'hC100, 8'h02);
    check_outs();
    rd_check("R1 ignored writes", 16'h4101, 8'h00, exp_rd(8'h00));

    rd_check("R10 index port read", 16'h4100, 8'h3C, 8'h3C);
    rd_check("R10 miss read high", 16'hC101, 8'h77, 8'h77);
    rd_check("R10 miss read low", 16'h4001, 8'h81, 8'h81);
    rd_check("R10 miss read even", 16'h5100, 8'hE4, 8'hE4);

    wr(16'h4100, 8'h07); midx = 3'd7;
    for (int c = 0; c < 4; c++) begin
      wr(16'h4101, 8'(c << 1)); mregs[7] = 3'(c << 1);
      check_outs();
      chk("R8 alt nt_sel", {4'b0, nt_alt}, {4'b0, exp_nt(c[1:0])});
    end

    strap = 1'b1;
    wr(16'h4100, 8'h00); midx = 3'd4;
    wr(16'h4101, 8'h00); mregs[4] = 3'd4;
    rd_check("R4 strap read bit2 open", 16'h4101, 8'h00, 8'h00);
    strap = 1'b0;
    rd_check("R4 strap stored bit2", 16'h4101, 8'h00, 8'h04);
    chk("R2 alt rd path", rd_alt, 8'h04);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule